// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous requester and an asynchronous static RAM that qualifies writes with two chip enables, one active low and one active high, plus an active-low write strobe. A single-cycle request carrying an address and a data word is turned into a full write cycle on the memory pins. The address, data and both enables are driven first. The strobe is then pulsed low. A recovery interval follows with the strobe high and the address and data held. At the end the enables are released and completion is reported.

The memory's timing minimums are given as nanosecond parameters together with the clock period. Package functions convert them to whole clock cycles by rounding up, and every phase lasts at least one cycle. The strobe's rising edge always terminates the write. Data setup, pulse width, address and enable lead time, and the total cycle length are all timed against that edge. Every pin is driven straight from a flop, so the strobe cannot glitch. While a cycle is in flight the ready output is low and any incoming request is dropped, so a caller holds its request until ready returns.

Top module: `sram_wr_seq`

## Requirements
- R1: The write strobe `mem_we_n` is low only while `mem_ce_n` is 0 and `mem_ce` is 1. Both enables stay asserted through the strobe and recovery phases, so the strobe's rising edge is always the edge that ends the write.
- R2: An accepted request's address and data appear on `mem_addr` and `mem_data` in the first cycle the enables are asserted. They stay unchanged for as long as the enables are asserted, including the cycle in which the strobe rises.
- R3: The strobe stays low for exactly STROBE_N consecutive cycles, where STROBE_N = max(1, ceil(T_PWE_NS / CLK_NS)).
- R4: Address, data and enables are held for at least ceil(max(T_SD_NS, T_AW_NS, T_SCE_NS) / CLK_NS) cycles before the strobe rises. At least one of those cycles has the strobe high.
- R5: The enables are asserted for exactly SETUP_N + STROBE_N + RECOVER_N cycles. SETUP_N is max(1, lead cycles − STROBE_N). RECOVER_N is max(1, ceil(T_WC_NS / CLK_NS) − SETUP_N − STROBE_N). The total is therefore never below ceil(T_WC_NS / CLK_NS).
- R6: A request that arrives while `wr_ready` is 0 is ignored. It causes no write cycle and does not change `mem_addr` or `mem_data`.
- R7: `wr_done` is a single-cycle pulse in the first cycle after the enables are released, and `wr_ready` is 1 in that same cycle. A request held through that cycle is accepted at the next clock edge, so the next cycle's enables follow after exactly one idle cycle.
- R8: During and after reset the pins show `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, with `wr_ready`=1 and `wr_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, sampled when wr_ready is 1 |
| wr_addr | input | ADDR_W | Address of the requested write |
| wr_data | input | DATA_W | Data of the requested write |
| wr_ready | output | 1 | High when a new request will be accepted |
| wr_done | output | 1 | One-cycle pulse when the memory is free again |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_data | output | DATA_W | Data pins of the memory (write direction only) |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The completion pulse of one write and the acceptance of the next request can fall in the same cycle, because `wr_ready` rises together with `wr_done`. The bench provokes this by issuing writes back to back, with each request raised as soon as ready is seen. The scoreboard checks that each write still lands with the right address and data. It also checks that the next enable window opens after exactly one idle cycle, and that its strobe width and lead time are not shortened.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Whole cycles covering t_ns, never fewer than one.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int strobe_cyc(input int pwe_ns, input int clk_ns);
    return ns_to_cyc(pwe_ns, clk_ns);
  endfunction

  // Cycles that address, data and enables must lead the strobe's rising edge.
  function automatic int lead_cyc(input int sd_ns, input int aw_ns,
                                  input int sce_ns, input int clk_ns);
    return ns_to_cyc(imax(sd_ns, imax(aw_ns, sce_ns)), clk_ns);
  endfunction

  function automatic int setup_cyc(input int lead, input int strobe);
    return imax(1, lead - strobe);
  endfunction

  function automatic int recover_cyc(input int wc_ns, input int clk_ns,
                                     input int setup, input int strobe);
    return imax(1, ns_to_cyc(wc_ns, clk_ns) - setup - strobe);
  endfunction

  function automatic int cnt_width(input int n);
    return imax(1, $clog2(n + 1));
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  // Loading N makes 'last' rise in the N-th cycle of the new phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_N   = 1,
  parameter int STROBE_N  = 2,
  parameter int RECOVER_N = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             last,
  output phase_t           phase,
  output phase_t           phase_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             finish
);

  localparam logic [CNT_W-1:0] SETUP_V   = CNT_W'(SETUP_N);
  localparam logic [CNT_W-1:0] STROBE_V  = CNT_W'(STROBE_N);
  localparam logic [CNT_W-1:0] RECOVER_V = CNT_W'(RECOVER_N);

  always_comb begin
    phase_nxt = phase;
    load      = 1'b0;
    load_val  = '0;
    accept    = 1'b0;
    finish    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (req) begin
          accept    = 1'b1;
          phase_nxt = PH_SETUP;
          load      = 1'b1;
          load_val  = SETUP_V;
        end
      end
      PH_SETUP: begin
        if (last) begin
          phase_nxt = PH_STROBE;
          load      = 1'b1;
          load_val  = STROBE_V;
        end
      end
      PH_STROBE: begin
        if (last) begin
          phase_nxt = PH_RECOVER;
          load      = 1'b1;
          load_val  = RECOVER_V;
        end
      end
      PH_RECOVER: begin
        if (last) begin
          finish    = 1'b1;
          phase_nxt = PH_IDLE;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish,
  input  phase_t            phase_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              ce_lo_n,
  output logic              ce_hi,
  output logic              we_n,
  output logic              done,
  output logic              ready
);

  logic busy_nxt;
  assign busy_nxt = (phase_nxt != PH_IDLE);

  // Every pin comes from a flop; the address and data only load on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_data <= '0;
      ce_lo_n  <= 1'b1;
      ce_hi    <= 1'b0;
      we_n     <= 1'b1;
      done     <= 1'b0;
      ready    <= 1'b1;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_data <= req_data;
      end
      ce_lo_n <= !busy_nxt;
      ce_hi   <= busy_nxt;
      we_n    <= (phase_nxt != PH_STROBE);
      done    <= finish;
      ready   <= !busy_nxt;
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_PWE_NS  = 8,
  parameter int T_SD_NS   = 8,
  parameter int T_AW_NS   = 10,
  parameter int T_SCE_NS  = 10,
  parameter int T_WC_NS   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              wr_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n
);

  localparam int STROBE_N  = strobe_cyc(T_PWE_NS, CLK_NS);
  localparam int LEAD_N    = lead_cyc(T_SD_NS, T_AW_NS, T_SCE_NS, CLK_NS);
  localparam int SETUP_N   = setup_cyc(LEAD_N, STROBE_N);
  localparam int RECOVER_N = recover_cyc(T_WC_NS, CLK_NS, SETUP_N, STROBE_N);
  localparam int CNT_W     = cnt_width(imax(SETUP_N, imax(STROBE_N, RECOVER_N)));

  // Named internal events, visible to the bound checker.
  phase_t           phase;
  phase_t           phase_nxt;
  logic             ev_accept;
  logic             ev_finish;
  logic             ev_phase_last;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (ev_phase_last)
  );

  sram_wr_ctrl #(
    .CNT_W     (CNT_W),
    .SETUP_N   (SETUP_N),
    .STROBE_N  (STROBE_N),
    .RECOVER_N (RECOVER_N)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (wr_req),
    .last      (ev_phase_last),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .load      (tmr_load),
    .load_val  (tmr_val),
    .accept    (ev_accept),
    .finish    (ev_finish)
  );

  sram_wr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ev_accept),
    .finish    (ev_finish),
    .phase_nxt (phase_nxt),
    .req_addr  (wr_addr),
    .req_data  (wr_data),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .ce_lo_n   (mem_ce_n),
    .ce_hi     (mem_ce),
    .we_n      (mem_we_n),
    .done      (wr_done),
    .ready     (wr_ready)
  );

endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_PWE_NS = 8,
  parameter int T_SD_NS  = 8,
  parameter int T_AW_NS  = 10,
  parameter int T_SCE_NS = 10,
  parameter int T_WC_NS  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              wr_ready,
  input logic              wr_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n
);

  localparam int STROBE_N = strobe_cyc(T_PWE_NS, CLK_NS);
  localparam int LEAD_N   = lead_cyc(T_SD_NS, T_AW_NS, T_SCE_NS, CLK_NS);
  localparam int SETUP_N  = setup_cyc(LEAD_N, STROBE_N);
  localparam int TOTAL_N  = SETUP_N + STROBE_N + recover_cyc(T_WC_NS, CLK_NS, SETUP_N, STROBE_N);
  localparam int WC_N     = ns_to_cyc(T_WC_NS, CLK_NS);

  logic [15:0] low_cnt;
  logic [15:0] act_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      act_cnt <= '0;
    end else begin
      low_cnt <= mem_we_n ? 16'd0 : low_cnt + 16'd1;
      act_cnt <= mem_ce_n ? 16'd0 : act_cnt + 16'd1;
    end
  end

  a_r1_strobe_inside_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce));

  a_r2_pins_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_data)));

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !$past(mem_we_n)) |-> (low_cnt == 16'(STROBE_N)));

  a_r4_lead_time: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !$past(mem_we_n)) |-> (act_cnt >= 16'(LEAD_N) && act_cnt > low_cnt));

  a_r5_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_n && !$past(mem_ce_n)) |-> (act_cnt == 16'(TOTAL_N) && act_cnt >= 16'(WC_N)));

  a_r6_busy_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ready) |=> ($stable(mem_addr) && $stable(mem_data)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  a_r7_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (wr_ready && mem_ce_n && !mem_ce));

endmodule

bind sram_wr_seq sram_wr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .T_PWE_NS(T_PWE_NS),
  .T_SD_NS(T_SD_NS), .T_AW_NS(T_AW_NS), .T_SCE_NS(T_SCE_NS), .T_WC_NS(T_WC_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ready(wr_ready), .wr_done(wr_done),
  .mem_addr(mem_addr), .mem_data(mem_data), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
  .mem_we_n(mem_we_n)
);

// File: tb/tb_sram_wr_seq.sv
`timescale 1ns/1ps
module tb_sram_wr_seq;

  localparam int AW = 13, DW = 8, CLK = 5;
  localparam int PWE = 8, SD = 8, AWT = 10, SCE = 10, WC = 12;

  function automatic int up(input int n, input int d);
    return n / d + (((n % d) != 0) ? 1 : 0);
  endfunction
  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  localparam int E_STROBE = atleast1(up(PWE, CLK));
  localparam int E_LEAD   = up((SD > AWT ? (SD > SCE ? SD : SCE) : (AWT > SCE ? AWT : SCE)), CLK);
  localparam int E_SETUP  = atleast1(E_LEAD - E_STROBE);
  localparam int E_WC     = up(WC, CLK);
  localparam int E_TOTAL  = E_SETUP + E_STROBE + atleast1(E_WC - E_SETUP - E_STROBE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, wr_done, mem_ce_n, mem_ce, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  always #2.5 clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .T_PWE_NS(PWE), .T_SD_NS(SD),
                .T_AW_NS(AWT), .T_SCE_NS(SCE), .T_WC_NS(WC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_done(wr_done), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n)
  );

  int n_cmp = 0, n_bad = 0;
  int pushed = 0, seen = 0, tight = 0;
  logic [AW+DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Driver: wait for ready, present one request for one cycle, queue the expectation.
  task automatic write_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    exp_q.push_back({a, d});
    pushed++;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  // Monitor / scoreboard, sampling outputs on the falling edge.
  logic mon_en = 1'b0;
  logic prev_we = 1'b1, prev_ce_n = 1'b1, want_done_low = 1'b0;
  int low_run = 0, act_run = 0, idle_run = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (want_done_low) begin
        chk(wr_done == 1'b0, "R7", "done lasts one cycle", int'(wr_done), 0);
        want_done_low = 1'b0;
      end
      if (!mem_we_n)
        chk(!mem_ce_n && mem_ce, "R1", "enables during strobe", int'({mem_ce_n, mem_ce}), 1);
      if (!mem_ce_n && prev_ce_n && idle_run == 1) tight++;
      if (mem_we_n && !prev_we) begin
        logic [AW+DW-1:0] e;
        seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected write", seen, pushed);
        end else begin
          e = exp_q.pop_front();
          chk(mem_addr == e[AW+DW-1:DW], "R2", "address at write end", int'(mem_addr), int'(e[AW+DW-1:DW]));
          chk(mem_data == e[DW-1:0], "R2", "data at write end", int'(mem_data), int'(e[DW-1:0]));
        end
        chk(low_run == E_STROBE, "R3", "strobe width", low_run, E_STROBE);
        chk(act_run >= E_LEAD && act_run > low_run, "R4", "lead before strobe rise", act_run, E_LEAD);
      end
      if (mem_ce_n && !prev_ce_n) begin
        chk(act_run == E_TOTAL && act_run >= E_WC, "R5", "enable window", act_run, E_TOTAL);
        chk(wr_done && wr_ready, "R7", "done and ready at release", int'({wr_done, wr_ready}), 3);
        want_done_low = 1'b1;
      end
      low_run  = mem_we_n ? 0 : low_run + 1;
      act_run  = mem_ce_n ? 0 : act_run + 1;
      idle_run = mem_ce_n ? idle_run + 1 : 0;
      prev_we   = mem_we_n;
      prev_ce_n = mem_ce_n;
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [AW-1:0] held_a;
    int t0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && !mem_ce && mem_we_n && wr_ready && !wr_done, "R8", "pins in reset",
        int'({mem_ce_n, mem_ce, mem_we_n, wr_ready, wr_done}), 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce && mem_we_n && wr_ready && !wr_done, "R8", "pins after reset",
        int'({mem_ce_n, mem_ce, mem_we_n, wr_ready, wr_done}), 5'b10110);
    mon_en = 1'b1;

    // Spaced writes with assorted patterns, including the address extremes.
    write_one('0, 8'h00);
    repeat (8) @(negedge clk);
    write_one({AW{1'b1}}, 8'hFF);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      write_one(AW'(i * 1237 + 5), DW'(i * 37 + 90));
      repeat (3 + i) @(negedge clk);
    end

    // Back to back: completion and next acceptance in the same cycle (R7).
    t0 = tight;
    for (int i = 0; i < 4; i++) write_one(AW'(13'h0AAA ^ AW'(i)), DW'(8'h55 + i));
    repeat (10) @(negedge clk);
    chk(tight - t0 == 3, "R7", "one idle cycle between streamed writes", tight - t0, 3);

    // Requests while busy must be dropped (R6).
    write_one(13'h0123, 8'hC3);
    held_a = mem_addr;
    wr_req = 1'b1; wr_addr = 13'h1F0F; wr_data = 8'h3C;
    @(negedge clk);
    chk(mem_addr == held_a && wr_ready == 1'b0, "R6", "address while busy", int'(mem_addr), int'(held_a));
    @(negedge clk);
    wr_req = 1'b0;
    chk(mem_addr == held_a && mem_data == 8'hC3, "R6", "pins while busy", int'(mem_data), 8'hC3);
    repeat (12) @(negedge clk);
    chk(seen == pushed && exp_q.size() == 0, "R6", "write count", seen, pushed);
    chk(mem_addr == 13'h0123, "R6", "address after busy request", int'(mem_addr), 13'h0123);

    summary();
    $finish;
  end

endmodule